// File: doc/BRIEF.md
# Disk Boot Sector Loader

This block runs once after reset. It keeps the processor stopped and off the bus, and it fills the top page of memory with boot code read from a spinning floppy disk. The boot image is stored in the final sector of every track. Because of that, the loader never checks which track the head is over and never reads header fields beyond the sector number. It waits for the first index pulse, which shows that the disk is turning. From then on it copies every occurrence of the chosen last sector into the page starting at `BASE_ADDR` (default $FF00), one byte per address in ascending order. A later copy simply overwrites an earlier one.

Once `INDEX_COUNT` index pulses (default 3) have been seen, transfers stop and the processor is let go, so it runs whatever copy was written last. If a sector copy is still under way at that moment, it is finished first. If the disk never turns, the loader flags an error and keeps the processor held.

The sequencer has five states. `ST_WAIT_INDEX` is entered at reset and waits for spin-up. `ST_LOADING` captures sectors and counts index pulses. `ST_DRAIN` finishes a copy that was open at the stop point. `ST_RELEASED` frees the processor. `ST_FAULT` means no index pulse arrived in time. The transitions are:
- WAIT_INDEX to LOADING on an index pulse.
- LOADING to RELEASED on the final index pulse with no copy open.
- LOADING to DRAIN on the final index pulse with a copy open.
- DRAIN to RELEASED when that copy ends.
- WAIT_INDEX or LOADING to FAULT after `TIMEOUT` clocks without an index pulse.

RELEASED and FAULT are left only by reset.

Top module: `floppy_boot_dma`

## Requirements
- R1: While `rst_n` is low, `cpu_hold` is 1, `mem_we` is 0 and `boot_error` is 0, and the loader waits for an index pulse.
- R2: Sector markers and bytes that arrive before the first index pulse cause no write.
- R3: After the first index pulse, a marker whose `sector_num` equals `LAST_SECTOR` opens a copy at offset 0. Each following `byte_valid` produces `mem_we`=1 one clock later, with `mem_addr` = `BASE_ADDR` + offset and `mem_wdata` equal to that byte. The offset then increases by one.
- R4: A marker with any other sector number is not copied. If a copy is open when such a marker arrives, the copy is closed and the rest of its bytes are not written.
- R5: A byte presented in the same cycle as a sector marker is not written.
- R6: A copy closes after its `SECTOR_BYTES`-th (256th) byte. Later bytes without a new marker are not written.
- R7: When the `INDEX_COUNT`-th index pulse is sampled with no copy open, `cpu_hold` falls at that same clock edge.
- R8: When a copy is open at the `INDEX_COUNT`-th index pulse, it continues to its last byte. That byte's write strobe appears with `cpu_hold` still 1, and `cpu_hold` falls at the next edge.
- R9: Once released, the loader makes no further writes, and `cpu_hold` stays 0 until reset.
- R10: `TIMEOUT` consecutive clocks without an index pulse, while waiting or loading, set `boot_error` to 1. After that, `cpu_hold` stays 1, no further writes occur, and index pulses are ignored.
- R11: An index pulse in the cycle in which the timeout would expire counts as an index pulse, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| index_pulse | input | 1 | One-cycle pulse per disk revolution |
| sector_start | input | 1 | One-cycle marker at the start of a sector's data |
| sector_num | input | SNUM_W | Sector number, valid with `sector_start` |
| byte_valid | input | 1 | Data byte strobe from the data separator |
| byte_data | input | 8 | Data byte |
| cpu_hold | output | 1 | 1 keeps the processor stopped and off the bus |
| boot_error | output | 1 | 1 when no index pulse arrived within `TIMEOUT` |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |

## Verification
Two pairs of events can share a clock.

The first pair is the stopping index pulse and a byte of an open copy. The bench drives the final index pulse in the middle of the 101st byte of a last-sector copy. It then checks four things: the copy runs on to all 256 bytes, the final write strobe is seen with the hold still asserted, the hold drops exactly one edge later, and the page holds the new image.

The second pair is timeout expiry and an index pulse. The bench places a pulse on the exact expiry clock and checks that no error appears and that the loader goes on to release after the remaining pulses.

A behavioural model, updated every clock, judges the strobe, address, data, hold and error outputs throughout all of these runs.

// File: rtl/boot_dma_pkg.sv
package boot_dma_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_INDEX,
        ST_LOADING,
        ST_DRAIN,
        ST_RELEASED,
        ST_FAULT
    } boot_state_t;

endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_dma_pkg::*;
#(
    parameter int INDEX_COUNT = 3,
    parameter int TIMEOUT     = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        index_pulse,
    input  logic        cap_busy,
    output boot_state_t state,
    output logic        cpu_hold,
    output logic        boot_error
);
    localparam int IDX_W = $clog2(INDEX_COUNT + 1);
    localparam int TMO_W = $clog2(TIMEOUT + 1);

    boot_state_t      state_nxt;
    logic [IDX_W-1:0] idx_cnt;
    logic [TMO_W-1:0] quiet_cnt;
    logic             last_index;
    logic             quiet_expired;
    logic             counting;

    assign counting      = (state == ST_WAIT_INDEX) || (state == ST_LOADING);
    assign last_index    = (idx_cnt == IDX_W'(INDEX_COUNT - 1));
    assign quiet_expired = (quiet_cnt == TMO_W'(TIMEOUT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_cnt   <= '0;
            quiet_cnt <= '0;
        end else if (counting) begin
            if (index_pulse) begin
                idx_cnt   <= idx_cnt + 1'b1;
                quiet_cnt <= '0;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_INDEX;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_INDEX: begin
                if (index_pulse)        state_nxt = last_index ? ST_RELEASED : ST_LOADING;
                else if (quiet_expired) state_nxt = ST_FAULT;
            end
            ST_LOADING: begin
                if (index_pulse) begin
                    if (last_index) state_nxt = cap_busy ? ST_DRAIN : ST_RELEASED;
                end else if (quiet_expired) begin
                    state_nxt = ST_FAULT;
                end
            end
            ST_DRAIN:    if (!cap_busy) state_nxt = ST_RELEASED;
            ST_RELEASED: state_nxt = ST_RELEASED;
            ST_FAULT:    state_nxt = ST_FAULT;
            default:     state_nxt = ST_WAIT_INDEX;
        endcase
    end

    always_comb begin
        cpu_hold   = (state != ST_RELEASED);
        boot_error = (state == ST_FAULT);
    end

    AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RELEASED |=> state == ST_RELEASED) else $error("release left"); // R9

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FAULT |=> state == ST_FAULT) else $error("fault left"); // R10

    AST_DRAIN_ON_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && $past(state) != ST_DRAIN) |-> $past(index_pulse) && $past(cap_busy))
        else $error("drain without stopping pulse"); // R8

endmodule

// File: rtl/sector_capture.sv
module sector_capture #(
    parameter int LAST_SECTOR  = 17,
    parameter int SNUM_W       = 8,
    parameter int SECTOR_BYTES = 256,
    parameter int ADDR_W       = 16,
    parameter int BASE_ADDR    = 'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_en,
    input  logic              byte_en,
    input  logic              sector_start,
    input  logic [SNUM_W-1:0] sector_num,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              cap_busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we
);
    localparam int OFF_W = $clog2(SECTOR_BYTES);

    logic [OFF_W-1:0] offset;
    logic             is_target;
    logic             take_byte;

    assign is_target = (sector_num == SNUM_W'(LAST_SECTOR));
    assign take_byte = !sector_start && byte_valid && byte_en && cap_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_busy  <= 1'b0;
            offset    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= ADDR_W'(BASE_ADDR);
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (sector_start) begin
                cap_busy <= start_en && is_target;
                offset   <= '0;
            end else if (take_byte) begin
                mem_we    <= 1'b1;
                mem_addr  <= ADDR_W'(BASE_ADDR) + ADDR_W'(offset);
                mem_wdata <= byte_data;
                offset    <= offset + 1'b1;
                if (offset == OFF_W'(SECTOR_BYTES - 1)) cap_busy <= 1'b0;
            end
        end
    end

    AST_WRITE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(byte_valid)) else $error("write without byte"); // R3

    AST_NO_WRITE_ON_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(sector_start)) else $error("byte taken with marker"); // R5

    AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= ADDR_W'(BASE_ADDR)) &&
                   (mem_addr <= ADDR_W'(BASE_ADDR + SECTOR_BYTES - 1)))
        else $error("address outside page"); // R6

endmodule

// File: rtl/floppy_boot_dma.sv
module floppy_boot_dma
    import boot_dma_pkg::*;
#(
    parameter int INDEX_COUNT  = 3,
    parameter int LAST_SECTOR  = 17,
    parameter int SNUM_W       = 8,
    parameter int SECTOR_BYTES = 256,
    parameter int ADDR_W       = 16,
    parameter int BASE_ADDR    = 'hFF00,
    parameter int TIMEOUT      = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              index_pulse,
    input  logic              sector_start,
    input  logic [SNUM_W-1:0] sector_num,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              cpu_hold,
    output logic              boot_error,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we
);
    boot_state_t state;
    logic        cap_busy;
    logic        start_en;
    logic        byte_en;

    assign start_en = (state == ST_LOADING);
    assign byte_en  = (state == ST_LOADING) || (state == ST_DRAIN);

    boot_seq_fsm #(
        .INDEX_COUNT (INDEX_COUNT),
        .TIMEOUT     (TIMEOUT)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .index_pulse (index_pulse),
        .cap_busy    (cap_busy),
        .state       (state),
        .cpu_hold    (cpu_hold),
        .boot_error  (boot_error)
    );

    sector_capture #(
        .LAST_SECTOR  (LAST_SECTOR),
        .SNUM_W       (SNUM_W),
        .SECTOR_BYTES (SECTOR_BYTES),
        .ADDR_W       (ADDR_W),
        .BASE_ADDR    (BASE_ADDR)
    ) i_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_en     (start_en),
        .byte_en      (byte_en),
        .sector_start (sector_start),
        .sector_num   (sector_num),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .cap_busy     (cap_busy),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_we       (mem_we)
    );

    AST_NO_WRITE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hold |-> !mem_we) else $error("write while released"); // R9

    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_hold) |-> $past(index_pulse) || $past(state) == ST_DRAIN)
        else $error("release without cause"); // R7

    AST_NO_WRITE_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_error && $past(boot_error)) |-> !mem_we) else $error("write in fault"); // R10

endmodule

// File: tb/test_floppy_boot_dma.sv
module test_floppy_boot_dma;
    localparam int IDX  = 3;
    localparam int LAST = 3;
    localparam int TMO  = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       index_pulse = 1'b0;
    logic       sector_start = 1'b0;
    logic [7:0] sector_num = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cpu_hold, boot_error, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    floppy_boot_dma #(
        .INDEX_COUNT (IDX),
        .LAST_SECTOR (LAST),
        .TIMEOUT     (TMO)
    ) i_floppy_boot_dma (
        .clk (clk), .rst_n (rst_n), .index_pulse (index_pulse),
        .sector_start (sector_start), .sector_num (sector_num),
        .byte_valid (byte_valid), .byte_data (byte_data),
        .cpu_hold (cpu_hold), .boot_error (boot_error),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_we (mem_we)
    );

    // behavioural reference: phase 0 wait, 1 load, 2 drain, 3 released, 4 fault
    int   m_phase, m_idx, m_quiet, m_off, was_busy, phase_now;
    bit   m_busy, e_we;
    int   e_addr, e_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_quiet = 0; m_busy = 0; m_off = 0;
            e_we = 0; e_addr = 'hFF00; e_data = 0;
        end else begin
            was_busy  = m_busy;
            phase_now = m_phase;
            e_we = 0;
            if (sector_start) begin
                m_busy = (phase_now == 1) && (sector_num == LAST);
                m_off  = 0;
            end else if (byte_valid && m_busy && (phase_now == 1 || phase_now == 2)) begin
                e_we = 1; e_addr = 'hFF00 + m_off; e_data = byte_data;
                m_off++;
                if (m_off == 256) m_busy = 0;
            end
            if (phase_now <= 1) begin
                if (index_pulse) begin
                    m_idx++; m_quiet = 0;
                    if (m_idx == IDX) m_phase = (was_busy != 0) ? 2 : 3;
                    else m_phase = 1;
                end else begin
                    m_quiet++;
                    if (m_quiet == TMO) m_phase = 4;
                end
            end else if (phase_now == 2) begin
                if (was_busy == 0) m_phase = 3;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison and shadow memory
    logic [7:0] ram [256];
    int wr_count;
    always @(negedge clk) begin
        if (!rst_n) begin
            wr_count = 0;
            for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        end else if (!done) begin
            check("R3 write strobe", int'(mem_we), int'(e_we));
            if (e_we) begin
                check("R3 address", int'(mem_addr), e_addr);
                check("R3 data", int'(mem_wdata), e_data);
            end
            check("R7 hold", int'(cpu_hold), int'(m_phase != 3));
            check("R10 error", int'(boot_error), int'(m_phase == 4));
            if (mem_we) begin
                wr_count++;
                ram[mem_addr[7:0]] = mem_wdata;
            end
        end
    end

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed + i * 13) & 255);
    endfunction

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic settle();
        repeat (2) tick();
    endtask

    task automatic pulse_index();
        index_pulse = 1'b1; tick(); index_pulse = 1'b0;
    endtask

    task automatic send_sector(int num, int n, int seed, bit collide);
        sector_start = 1'b1; sector_num = 8'(num);
        byte_valid = collide; byte_data = 8'hEE;
        tick();
        sector_start = 1'b0; byte_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = pat(seed, i); tick();
        end
        byte_valid = 1'b0;
    endtask

    task automatic check_ram(string req, int seed);
        int bad = -1;
        for (int i = 0; i < 256; i++)
            if (bad < 0 && ram[i] != pat(seed, i)) bad = i;
        if (bad < 0) check(req, 0, 0);
        else check(req, int'(ram[bad]), int'(pat(seed, bad)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; index_pulse = 0; sector_start = 0; byte_valid = 0;
        repeat (3) tick();
        @(negedge clk);
        check("R1 hold in reset", int'(cpu_hold), 1);
        check("R1 strobe in reset", int'(mem_we), 0);
        check("R1 error in reset", int'(boot_error), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        // main load over two revolutions
        do_reset();
        send_sector(LAST, 256, 'h11, 0);
        settle();
        check("R2 no write before first index", wr_count, 0);
        pulse_index();
        for (int s = 0; s < LAST; s++) send_sector(s, 256, 'h30 + s, 0);
        send_sector(LAST, 256, 'h20, 1);
        for (int i = 0; i < 4; i++) begin
            byte_valid = 1'b1; byte_data = 8'h99; tick();
        end
        byte_valid = 1'b0;
        settle();
        check("R6 only 256 bytes per copy", wr_count, 256);
        check_ram("R5 colliding byte dropped, R3 image", 'h20);
        pulse_index();
        send_sector(LAST, 50, 'h40, 0);
        send_sector(0, 20, 'h33, 0);
        settle();
        check("R4 copy closed by other marker", wr_count, 306);
        send_sector(LAST, 256, 'h55, 0);
        settle();
        check_ram("R3 second image", 'h55);
        pulse_index();
        @(negedge clk);
        check("R7 hold falls on final index", int'(cpu_hold), 0);
        send_sector(LAST, 10, 'h66, 0);
        settle();
        check("R9 no write after release", wr_count, 562);
        check("R9 hold stays low", int'(cpu_hold), 0);

        // stop pulse lands inside an open copy
        do_reset();
        pulse_index();
        send_sector(LAST, 256, 'h60, 0);
        pulse_index();
        sector_start = 1'b1; sector_num = 8'(LAST); tick(); sector_start = 1'b0;
        for (int i = 0; i < 256; i++) begin
            byte_valid = 1'b1; byte_data = pat('h70, i);
            index_pulse = (i == 100);
            tick();
        end
        byte_valid = 1'b0; index_pulse = 1'b0;
        @(negedge clk);
        check("R8 last strobe present", int'(mem_we), 1);
        check("R8 hold kept with last strobe", int'(cpu_hold), 1);
        tick();
        @(negedge clk);
        check("R8 hold falls one edge later", int'(cpu_hold), 0);
        settle();
        check_ram("R8 drained image", 'h70);

        // index pulse on the expiry clock
        do_reset();
        repeat (TMO - 1) tick();
        pulse_index();
        @(negedge clk);
        check("R11 no error on coincident index", int'(boot_error), 0);
        pulse_index();
        pulse_index();
        @(negedge clk);
        check("R11 release after remaining pulses", int'(cpu_hold), 0);

        // disk never turns
        do_reset();
        repeat (TMO + 2) tick();
        @(negedge clk);
        check("R10 error raised", int'(boot_error), 1);
        check("R10 hold kept", int'(cpu_hold), 1);
        pulse_index();
        send_sector(LAST, 8, 'h77, 0);
        settle();
        check("R10 error sticky", int'(boot_error), 1);
        check("R10 hold sticky", int'(cpu_hold), 1);
        check("R10 no writes in fault", wr_count, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule